// File: doc/BRIEF.md
# Staged Graphics Power-Gating Sequencer

This controller takes a graphics engine from full power down to a power-gated state in ordered steps, and brings it back. It watches two inputs. The first is an engine-idle level. The second is a register-bus activity flag.

When the engine is idle and the register bus is quiet, the sequencer lowers the engine's clocks through request/acknowledge handshakes with the clock generator. In staged mode it lowers the 3D partition first and the compute partition second. In direct mode it lowers both together. It then turns on coarse clock gating and waits a programmable number of cycles. After that wait it asks for a register save, and once the save is acknowledged it applies power gating.

Activity on the register bus, or the engine leaving idle, wakes the block. From the gated state it requests a register restore and then raises the clocks in the reverse order. If activity returns while the pre-gating delay is still running, the delay is abandoned. In that case no save or restore takes place, and the clocks are raised straight away.

All control and status pins are plain levels. There is no streaming data path. Each handshake works as follows: a request stays high until its acknowledge is sampled high on a rising clock edge, and it drops in the following cycle.

Top module: `gfx_pwr_seq`

## Requirements
- R1: After reset, state_o is 0, pwr_o is 2'b00, and busy_o, cg_en_o, pg_en_o and every request output are low.
- R2: In staged mode (direct_i=0), when the block is in the full state with eng_idle_i=1 and regbus_act_i=0, it raises ramp3d_req_o with ramp_up_o=0. rampcmp_req_o rises one cycle after the cycle in which ramp3d_ack_i is sampled, and pwr_o reads 2'b01 while the compute ramp is pending.
- R3: In direct mode (direct_i=1), both ramp requests rise in the same cycle, on the way down and on the way up. The sequence advances one cycle after the later of the two acknowledges. Each request drops after its own acknowledge.
- R4: Every request (both ramps, save, restore) stays high until its acknowledge is sampled, and the sequencer does not advance before that.
- R5: cg_en_o rises one cycle after the compute ramp-down completes. save_req_o rises exactly cg_delay_i+1 cycles after cg_en_o rises.
- R6: pg_en_o rises one cycle after save_ack_i is sampled, and never without cg_en_o. In the gated state, state_o=6, pwr_o=2'b10 and busy_o=0.
- R7: In the gated state, regbus_act_i=1 or eng_idle_i=0 causes, in the next cycle, pg_en_o to fall and rest_req_o to rise. After the restore acknowledge, staged mode raises the compute clock first (rampcmp_req_o with ramp_up_o=1). It raises the 3D clock one cycle after the compute acknowledge, and then returns to the full state.
- R8: A wake condition during the pre-gating delay drops cg_en_o in the next cycle and starts the ramp-up path. Neither save_req_o nor rest_req_o is raised.
- R9: state_o encodes the states as follows: 0 full, 1 3D down, 2 compute down, 3 both down, 4 delay, 5 save, 6 gated, 7 restore, 8 compute up, 9 3D up, 10 both up. busy_o is high in every state except full and gated. pwr_o is 2'b00 (both clocked), 2'b01 (3D down) or 2'b10 (both down).
- R10: While regbus_act_i=1, eng_idle_i=1 has no effect in the full state: the block raises no request and state_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_idle_i | input | 1 | Engine reports idle |
| regbus_act_i | input | 1 | Register-bus activity (wake trigger) |
| direct_i | input | 1 | 1: ramp both partitions together |
| cg_delay_i | input | DLY_W | Extra cycles to wait in clock gating before the save |
| ramp3d_req_o | output | 1 | 3D clock ramp request |
| ramp3d_ack_i | input | 1 | 3D clock ramp done |
| rampcmp_req_o | output | 1 | Compute clock ramp request |
| rampcmp_ack_i | input | 1 | Compute clock ramp done |
| ramp_up_o | output | 1 | Ramp direction: 1 up, 0 down |
| cg_en_o | output | 1 | Coarse clock gating enable |
| pg_en_o | output | 1 | Power gating enable |
| save_req_o | output | 1 | Register save request |
| save_ack_i | input | 1 | Register save done |
| rest_req_o | output | 1 | Register restore request |
| rest_ack_i | input | 1 | Register restore done |
| state_o | output | 4 | Current state code |
| pwr_o | output | 2 | Settled clock level |
| busy_o | output | 1 | Transition in progress |

## Verification
Full down-and-up cycles are run in staged and in direct mode, each with a different pair of ramp acknowledge latencies. The measured request-to-request spacing therefore shows whether the sequencer waited for the right acknowledge, and whether it used parallel or ordered ramps. The pre-gating delay is tried at zero and at several non-zero values, and wake is triggered once by register-bus activity and once by the idle flag falling. Cancellation runs drop the idle flag mid-delay: their event order has to skip save and restore, which separates a clean cancel from a late one. A directed case holds idle and bus activity high together to show that the full state ignores idle while the bus is busy.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
  typedef enum logic [3:0] {
    ST_FULL    = 4'd0,
    ST_DN3D    = 4'd1,
    ST_DNCMP   = 4'd2,
    ST_DNALL   = 4'd3,
    ST_CGWAIT  = 4'd4,
    ST_SAVE    = 4'd5,
    ST_GATED   = 4'd6,
    ST_RESTORE = 4'd7,
    ST_UPCMP   = 4'd8,
    ST_UP3D    = 4'd9,
    ST_UPALL   = 4'd10
  } gpg_state_e;

  typedef enum logic [1:0] {
    PW_FULL = 2'b00,
    PW_CMP  = 2'b01,
    PW_OFF  = 2'b10
  } gpg_pwr_e;

  localparam int NPART = 2;
  localparam int P3D   = 0;
  localparam int PCMP  = 1;
endpackage

// File: rtl/gpg_hs.sv
module gpg_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic ack,
  output logic req,
  output logic done
);
  logic got_q;

  // remember an acknowledge while the owning state is still active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) got_q <= 1'b0;
    else        got_q <= go & (got_q | ack);
  end

  assign req  = go & ~got_q;
  assign done = go & (got_q | ack);
endmodule

// File: rtl/gpg_delay.sv
module gpg_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  assign expired = run & (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gfx_pwr_seq.sv
module gfx_pwr_seq
  import gpg_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_idle_i,
  input  logic             regbus_act_i,
  input  logic             direct_i,
  input  logic [DLY_W-1:0] cg_delay_i,
  output logic             ramp3d_req_o,
  input  logic             ramp3d_ack_i,
  output logic             rampcmp_req_o,
  input  logic             rampcmp_ack_i,
  output logic             ramp_up_o,
  output logic             cg_en_o,
  output logic             pg_en_o,
  output logic             save_req_o,
  input  logic             save_ack_i,
  output logic             rest_req_o,
  input  logic             rest_ack_i,
  output logic [3:0]       state_o,
  output logic [1:0]       pwr_o,
  output logic             busy_o
);
  gpg_state_e state_q, state_d;

  logic wake, sleep;
  logic [NPART-1:0] ramp_go, ramp_ack, ramp_req, ramp_done;
  logic save_done, rest_done, dly_exp;
  logic both_done;

  assign wake  = regbus_act_i | ~eng_idle_i;
  assign sleep = eng_idle_i & ~regbus_act_i;

  assign ramp_ack[P3D]  = ramp3d_ack_i;
  assign ramp_ack[PCMP] = rampcmp_ack_i;

  assign ramp_go[P3D]  = (state_q == ST_DN3D)  || (state_q == ST_DNALL) ||
                         (state_q == ST_UP3D)  || (state_q == ST_UPALL);
  assign ramp_go[PCMP] = (state_q == ST_DNCMP) || (state_q == ST_DNALL) ||
                         (state_q == ST_UPCMP) || (state_q == ST_UPALL);

  for (genvar p = 0; p < NPART; p++) begin : g_ramp
    gpg_hs u_hs (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (ramp_go[p]),
      .ack  (ramp_ack[p]),
      .req  (ramp_req[p]),
      .done (ramp_done[p])
    );
  end

  assign both_done = &ramp_done;

  gpg_hs u_save (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (state_q == ST_SAVE),
    .ack  (save_ack_i),
    .req  (save_req_o),
    .done (save_done)
  );

  gpg_hs u_rest (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (state_q == ST_RESTORE),
    .ack  (rest_ack_i),
    .req  (rest_req_o),
    .done (rest_done)
  );

  gpg_delay #(.W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_CGWAIT),
    .limit  (cg_delay_i),
    .expired(dly_exp)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FULL:    if (sleep) state_d = direct_i ? ST_DNALL : ST_DN3D;
      ST_DN3D:    if (ramp_done[P3D])  state_d = ST_DNCMP;
      ST_DNCMP:   if (ramp_done[PCMP]) state_d = ST_CGWAIT;
      ST_DNALL:   if (both_done)       state_d = ST_CGWAIT;
      ST_CGWAIT: begin
        if (wake)         state_d = direct_i ? ST_UPALL : ST_UPCMP;
        else if (dly_exp) state_d = ST_SAVE;
      end
      ST_SAVE:    if (save_done) state_d = ST_GATED;
      ST_GATED:   if (wake)      state_d = ST_RESTORE;
      ST_RESTORE: if (rest_done) state_d = direct_i ? ST_UPALL : ST_UPCMP;
      ST_UPCMP:   if (ramp_done[PCMP]) state_d = ST_UP3D;
      ST_UP3D:    if (ramp_done[P3D])  state_d = ST_FULL;
      ST_UPALL:   if (both_done)       state_d = ST_FULL;
      default:    state_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FULL;
    else        state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_FULL, ST_DN3D, ST_DNALL: pwr_o = PW_FULL;
      ST_DNCMP, ST_UP3D:          pwr_o = PW_CMP;
      default:                    pwr_o = PW_OFF;
    endcase
  end

  assign ramp3d_req_o  = ramp_req[P3D];
  assign rampcmp_req_o = ramp_req[PCMP];
  assign ramp_up_o     = (state_q == ST_UPCMP) || (state_q == ST_UP3D) || (state_q == ST_UPALL);
  assign cg_en_o       = (state_q == ST_CGWAIT) || (state_q == ST_SAVE) || (state_q == ST_GATED);
  assign pg_en_o       = (state_q == ST_GATED);
  assign state_o       = state_q;
  assign busy_o        = (state_q != ST_FULL) && (state_q != ST_GATED);
endmodule

// File: rtl/gpg_chk.sv
module gpg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_idle_i,
  input logic       regbus_act_i,
  input logic       ramp3d_req_o,
  input logic       ramp3d_ack_i,
  input logic       rampcmp_req_o,
  input logic       rampcmp_ack_i,
  input logic       cg_en_o,
  input logic       pg_en_o,
  input logic       save_req_o,
  input logic       save_ack_i,
  input logic       rest_req_o,
  input logic       rest_ack_i,
  input logic [3:0] state_o,
  input logic       busy_o
);
  // R6
  pg_needs_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_en_o |-> cg_en_o);

  // R6
  pg_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_en_o) |-> $past(save_ack_i));

  // R4
  hold_3d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp3d_req_o && !ramp3d_ack_i) |=> ramp3d_req_o);

  // R4
  hold_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rampcmp_req_o && !rampcmp_ack_i) |=> rampcmp_req_o);

  // R4
  hold_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req_o && !save_ack_i) |=> save_req_o);

  // R4
  hold_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_req_o && !rest_ack_i) |=> rest_req_o);

  // R7
  restore_on_ungate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_en_o) |-> rest_req_o);

  // R7
  bus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd6 && regbus_act_i) |=> rest_req_o);

  // R8
  cancel_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd4 && (regbus_act_i || !eng_idle_i)) |=> (!save_req_o && !cg_en_o));

  // R9
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ramp3d_req_o && !rampcmp_req_o && !save_req_o && !rest_req_o));

  // R10
  bus_blocks_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd0 && regbus_act_i) |=> (state_o == 4'd0));
endmodule

bind gfx_pwr_seq gpg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_idle_i   (eng_idle_i),
  .regbus_act_i (regbus_act_i),
  .ramp3d_req_o (ramp3d_req_o),
  .ramp3d_ack_i (ramp3d_ack_i),
  .rampcmp_req_o(rampcmp_req_o),
  .rampcmp_ack_i(rampcmp_ack_i),
  .cg_en_o      (cg_en_o),
  .pg_en_o      (pg_en_o),
  .save_req_o   (save_req_o),
  .save_ack_i   (save_ack_i),
  .rest_req_o   (rest_req_o),
  .rest_ack_i   (rest_ack_i),
  .state_o      (state_o),
  .busy_o       (busy_o)
);

// File: tb/tb_gfx_pwr_seq.sv
`timescale 1ns/1ps
module tb_gfx_pwr_seq;
  localparam int DLY_W = 8;
  localparam int LSAVE = 1;
  localparam int LREST = 2;
  // fields: [18] direct, [17] cancel, [16] bus wake, [15:8] delay, [7:4] 3D latency, [3:0] compute latency
  localparam logic [18:0] ROWS [5] = '{
    {1'b0, 1'b0, 1'b0, 8'd3,  4'd1, 4'd2},
    {1'b1, 1'b0, 1'b1, 8'd0,  4'd3, 4'd1},
    {1'b0, 1'b1, 1'b0, 8'd20, 4'd0, 4'd0},
    {1'b1, 1'b1, 1'b0, 8'd15, 4'd2, 4'd5},
    {1'b0, 1'b0, 1'b1, 8'd7,  4'd5, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_idle_i = 1'b0, regbus_act_i = 1'b0, direct_i = 1'b0;
  logic [DLY_W-1:0] cg_delay_i = '0;
  logic ramp3d_ack_i = 1'b0, rampcmp_ack_i = 1'b0, save_ack_i = 1'b0, rest_ack_i = 1'b0;
  logic ramp3d_req_o, rampcmp_req_o, ramp_up_o, cg_en_o, pg_en_o, save_req_o, rest_req_o, busy_o;
  logic [3:0] state_o;
  logic [1:0] pwr_o;

  int checks = 0, fails = 0, cyc = 0;
  int lat3d = 0, latcmp = 0;
  int evs [16];
  int nev = 0;
  int tev [10];
  int pev [10];
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  gfx_pwr_seq #(.DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .eng_idle_i(eng_idle_i), .regbus_act_i(regbus_act_i),
    .direct_i(direct_i), .cg_delay_i(cg_delay_i),
    .ramp3d_req_o(ramp3d_req_o), .ramp3d_ack_i(ramp3d_ack_i),
    .rampcmp_req_o(rampcmp_req_o), .rampcmp_ack_i(rampcmp_ack_i),
    .ramp_up_o(ramp_up_o), .cg_en_o(cg_en_o), .pg_en_o(pg_en_o),
    .save_req_o(save_req_o), .save_ack_i(save_ack_i),
    .rest_req_o(rest_req_o), .rest_ack_i(rest_ack_i),
    .state_o(state_o), .pwr_o(pwr_o), .busy_o(busy_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic log_ev(int c);
    if (nev < 16) begin
      evs[nev] = c;
      nev++;
    end
    tev[c] = cyc;
    pev[c] = int'(pwr_o);
  endtask

  initial forever @(posedge clk) cyc++;

  // acknowledge responders
  initial begin
    int c3 = 0, cc = 0, cs = 0, cr = 0;
    forever @(negedge clk) begin
      ramp3d_ack_i  = ramp3d_req_o  && (c3 == lat3d);
      rampcmp_ack_i = rampcmp_req_o && (cc == latcmp);
      save_ack_i    = save_req_o    && (cs == LSAVE);
      rest_ack_i    = rest_req_o    && (cr == LREST);
      c3 = ramp3d_req_o  ? c3 + 1 : 0;
      cc = rampcmp_req_o ? cc + 1 : 0;
      cs = save_req_o    ? cs + 1 : 0;
      cr = rest_req_o    ? cr + 1 : 0;
    end
  end

  // event monitor: 1 3D down, 2 cmp down, 3 cg on, 4 save, 5 pg on, 6 restore, 7 cmp up, 8 3D up, 9 full
  initial begin
    logic p3 = 1'b0, pc = 1'b0, pcg = 1'b0, ps = 1'b0, ppg = 1'b0, pr = 1'b0;
    logic [3:0] pst = 4'd0;
    forever @(negedge clk) begin
      if (!ramp_up_o) begin
        if (ramp3d_req_o && !p3) log_ev(1);
        if (rampcmp_req_o && !pc) log_ev(2);
      end else begin
        if (rampcmp_req_o && !pc) log_ev(7);
        if (ramp3d_req_o && !p3) log_ev(8);
      end
      if (cg_en_o && !pcg) log_ev(3);
      if (save_req_o && !ps) log_ev(4);
      if (pg_en_o && !ppg) log_ev(5);
      if (rest_req_o && !pr) log_ev(6);
      if (state_o == 4'd0 && pst != 4'd0) log_ev(9);
      p3 = ramp3d_req_o; pc = rampcmp_req_o; pcg = cg_en_o;
      ps = save_req_o; ppg = pg_en_o; pr = rest_req_o; pst = state_o;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic run_row(int r);
    logic [18:0] row;
    bit d, cx, bw;
    int dly, l3, lc, mx, ok_seq;
    int exp_seq [9];
    int nexp;
    row = ROWS[r];
    d = row[18]; cx = row[17]; bw = row[16];
    dly = int'(row[15:8]); l3 = int'(row[7:4]); lc = int'(row[3:0]);
    mx = (l3 > lc) ? l3 : lc;
    @(negedge clk);
    lat3d = l3; latcmp = lc; direct_i = d; cg_delay_i = row[15:8];
    nev = 0;
    for (int i = 0; i < 10; i++) tev[i] = 0;
    eng_idle_i = 1'b1;
    if (cx) begin
      for (int i = 0; i < 300 && !cg_en_o; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      eng_idle_i = 1'b0;
    end else begin
      for (int i = 0; i < 600 && !pg_en_o; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      // R6 gated state settled
      chk(state_o == 4'd6 && busy_o == 1'b0 && cg_en_o, "R6 gated state", int'(state_o), 6);
      chk(pwr_o == 2'b10, "R6 gated pwr", int'(pwr_o), 2);
      if (bw) begin
        regbus_act_i = 1'b1;
        @(negedge clk);
        // R7 bus activity wakes while idle is still high
        chk(rest_req_o && !pg_en_o, "R7 bus wake restore", int'(rest_req_o), 1);
        regbus_act_i = 1'b0;
        eng_idle_i = 1'b0;
      end else begin
        eng_idle_i = 1'b0;
      end
    end
    for (int i = 0; i < 600 && !(state_o == 4'd0 && nev > 0 && evs[nev-1] == 9); i++) @(negedge clk);
    repeat (2) @(negedge clk);

    // expected event order
    if (cx) begin
      exp_seq = '{1, 2, 3, 7, 8, 9, 0, 0, 0}; nexp = 6;
    end else begin
      exp_seq = '{1, 2, 3, 4, 5, 6, 7, 8, 9}; nexp = 9;
    end
    ok_seq = (nev == nexp) ? 1 : 0;
    for (int i = 0; i < nexp && i < nev; i++) if (evs[i] != exp_seq[i]) ok_seq = 0;
    chk(ok_seq == 1, cx ? "R8 cancel sequence" : "R7 full sequence", nev, nexp);

    if (!d) begin
      // R2 staged: compute waits for 3D ack
      chk(tev[2] - tev[1] == l3 + 1, "R2 staged down spacing", tev[2] - tev[1], l3 + 1);
      chk(pev[2] == 1, "R2 pwr 3D off", pev[2], 1);
      // R4 cg waits for compute ack
      chk(tev[3] - tev[2] == lc + 1, "R4 wait compute ack", tev[3] - tev[2], lc + 1);
      // R7 staged up: 3D after compute ack
      chk(tev[8] - tev[7] == lc + 1, "R7 staged up spacing", tev[8] - tev[7], lc + 1);
    end else begin
      chk(tev[2] == tev[1], "R3 direct down together", tev[2] - tev[1], 0);
      chk(tev[3] - tev[1] == mx + 1, "R3 direct waits later ack", tev[3] - tev[1], mx + 1);
      chk(tev[8] == tev[7], "R3 direct up together", tev[8] - tev[7], 0);
    end
    if (!cx) begin
      chk(tev[4] - tev[3] == dly + 1, "R5 clock gate delay", tev[4] - tev[3], dly + 1);
      chk(tev[5] - tev[4] == LSAVE + 1, "R6 pg after save ack", tev[5] - tev[4], LSAVE + 1);
      chk(tev[7] - tev[6] == LREST + 1, "R4 ramp after restore ack", tev[7] - tev[6], LREST + 1);
    end else begin
      chk(tev[7] - tev[3] == 5, "R8 cancel ramps up next cycle", tev[7] - tev[3], 5);
    end
    chk(state_o == 4'd0 && pwr_o == 2'b00 && !busy_o, "R9 back at full", int'(state_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state_o == 4'd0 && pwr_o == 2'b00, "R1 reset state", int'(state_o), 0);
    chk(!busy_o && !cg_en_o && !pg_en_o, "R1 reset flags", int'(busy_o), 0);
    chk(!ramp3d_req_o && !rampcmp_req_o && !save_req_o && !rest_req_o, "R1 reset requests",
        int'(ramp3d_req_o | rampcmp_req_o | save_req_o | rest_req_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(state_o == 4'd0 && !busy_o, "R9 full after reset", int'(state_o), 0);

    for (int r = 0; r < 5; r++) run_row(r);

    // R10 idle ignored while bus busy
    regbus_act_i = 1'b1;
    eng_idle_i = 1'b1;
    repeat (10) @(negedge clk);
    chk(state_o == 4'd0 && !ramp3d_req_o && !rampcmp_req_o && !busy_o, "R10 bus holds full",
        int'(state_o), 0);
    eng_idle_i = 1'b0;
    regbus_act_i = 1'b0;
    repeat (2) @(negedge clk);

    // R9 busy during transition, state code of 3D ramp-down
    lat3d = 6; direct_i = 1'b0; cg_delay_i = 8'd2;
    eng_idle_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_o && state_o == 4'd1 && ramp3d_req_o, "R9 busy in 3D ramp", int'(state_o), 1);
    eng_idle_i = 1'b0;
    for (int i = 0; i < 300 && state_o != 4'd0; i++) @(negedge clk);
    chk(state_o == 4'd0, "R9 recovered", int'(state_o), 0);

    finish_run();
  end
endmodule